// File: doc/BRIEF.md
# ATM Cell Statistics Counter Bank

This block keeps the performance statistics for one ATM transmission-convergence channel. The receive and transmit datapaths each send a one-cycle strobe per event. Five events are counted:

- good cells received and forwarded,
- cells whose transmission completed,
- errored cells that were discarded,
- cells whose header was repaired by single-bit correction,
- idle cells sent.

Each event drives its own counter, which is `CW` bits wide (16 by default).

The host reads the counters through a reduced register port: a read strobe, an address and registered read data. A counter that passes its top value wraps to zero. The wrap sets a sticky status bit for that counter. The interrupt output is raised when a status bit is set and its mask bit is also set. A mode input selects whether a counter read also clears the counter. A second control input stops the corrected-cell count while single-bit correction is disabled.

Top module: `tc_cell_stats`

## Requirements
- R1: After reset, all counters, status bits and mask bits are zero, and `irq` is low.
- R2: Each event strobe that is high on a clock edge adds one to its counter. The counter addresses are: received-good 0, transmitted 1, errored 2, corrected 3, idle 4.
- R3: While `fix_off` is 1, `ev_rx_fix` has no effect, and the corrected counter (address 3) keeps its value.
- R4: A read presents the addressed value on `rdata` after the clock edge that samples `rd_en`. With `keep_on_read` at 0, a counter read also clears that counter to zero.
- R5: With `keep_on_read` at 1, a counter read leaves the counter unchanged.
- R6: If a counter's event arrives in the same cycle as a clearing read of that counter, the read returns the value held before the read, and the counter becomes 1.
- R7: An event on a counter that holds all ones makes the counter 0 and sets that counter's status bit. The status bit for the counter at address i is bit i.
- R8: Address 5 reads the status bits in `rdata[4:0]`. A write to address 5 clears each status bit whose `wdata` bit is 1. A wrap in the same cycle takes priority over the clear.
- R9: Address 6 holds the mask in bits [4:0], and it can be written and read back. `irq` is high exactly when some status bit and its mask bit are both 1.
- R10: A read of address 7 returns zero and changes no counter, even with `keep_on_read` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rx_good | input | 1 | Good cell received strobe |
| ev_tx_done | input | 1 | Cell transmission completed strobe |
| ev_rx_err | input | 1 | Errored cell discarded strobe |
| ev_rx_fix | input | 1 | Header corrected strobe |
| ev_tx_idle | input | 1 | Idle cell sent strobe |
| keep_on_read | input | 1 | 1: reads do not clear counters |
| fix_off | input | 1 | 1: single-bit correction disabled, corrected count frozen |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (status clear, mask load) |
| addr | input | AW | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Registered read data |
| irq | output | 1 | Masked overflow interrupt |

## Verification
Two things can hit one counter in the same cycle: a clearing host read and a counter event. The bench provokes this by raising the transmitted-cell strobe on the clock edge that samples a clearing read of that counter. It then judges two results. The returned data must be the count from before the read, and a second, non-clearing read must then find exactly 1. The bench uses a 5-bit counter width, so every counter can be swept through a full wrap. It compares each read against a count kept modulo 32 in the bench.

// File: rtl/tc_cell_stats.sv
module tc_cell_stats #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rx_good,
  input  logic          ev_tx_done,
  input  logic          ev_rx_err,
  input  logic          ev_rx_fix,
  input  logic          ev_tx_idle,
  input  logic          keep_on_read,
  input  logic          fix_off,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  localparam int NC = 5;
  localparam logic [AW-1:0] A_STS = AW'(NC);
  localparam logic [AW-1:0] A_MSK = AW'(NC + 1);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt [NC];
  logic [NC-1:0] ev, rclr, wrap, sts, msk;
  logic [CW-1:0] rd_val;
  logic          sts_wr, msk_wr;

  assign ev = {ev_tx_idle, ev_rx_fix & ~fix_off, ev_rx_err, ev_tx_done, ev_rx_good};
  assign sts_wr = wr_en && addr == A_STS;
  assign msk_wr = wr_en && addr == A_MSK;

  for (genvar i = 0; i < NC; i++) begin : g_cnt
    assign rclr[i] = rd_en && !keep_on_read && addr == AW'(i);
    assign wrap[i] = ev[i] && !rclr[i] && cnt[i] == TOP;

    always_ff @(posedge clk) begin
      if (!rst_n)       cnt[i] <= '0;
      else if (rclr[i]) cnt[i] <= CW'(ev[i]);
      else if (ev[i])   cnt[i] <= cnt[i] + 1'b1;
    end

    // R6
    clr_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rclr[i] && ev[i] |=> cnt[i] == CW'(1));
    // R5
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && keep_on_read && addr == AW'(i) && !ev[i] |=> $stable(cnt[i]));
    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] && !rclr[i] && cnt[i] == TOP |=> cnt[i] == '0 && sts[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      msk <= '0;
    end else begin
      sts <= (sts & ~(sts_wr ? wdata[NC-1:0] : '0)) | wrap;
      if (msk_wr) msk <= wdata[NC-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NC; i++)
      if (addr == AW'(i)) rd_val = cnt[i];
    if (addr == A_STS) rd_val = CW'(sts);
    if (addr == A_MSK) rd_val = CW'(msk);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign irq = |(sts & msk);

  // R3
  fix_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_off && !rclr[3] |=> $stable(cnt[3]));
  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr > A_MSK |=> rdata == '0);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msk_wr && wdata[NC-1:0] == '0 |=> !irq);
  // R8
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && wdata[NC-1:0] == '1 && wrap == '0 |=> sts == '0);
endmodule

// File: tb/tb_tc_cell_stats.sv
module tb_tc_cell_stats;
  localparam int CW = 5;
  localparam int AW = 3;
  localparam int M = 1 << CW;

  logic clk = 0, rst_n = 0;
  logic [4:0] evs = '0;
  logic keep_on_read = 1, fix_off = 0, rd_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  int exp_c [5];
  int exp_s = 0;
  logic [CW-1:0] v;

  always #4 clk = ~clk;

  tc_cell_stats #(.CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_good(evs[0]), .ev_tx_done(evs[1]), .ev_rx_err(evs[2]),
    .ev_rx_fix(evs[3]), .ev_tx_idle(evs[4]),
    .keep_on_read(keep_on_read), .fix_off(fix_off),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [CW-1:0] val);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; val = rdata;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = CW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(int i);
    @(negedge clk); evs[i] = 1;
    @(negedge clk); evs = '0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) exp_c[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: everything zero after reset
    for (int a = 0; a < 7; a++) begin rd(a, v); check("R1", v, 0); end
    check("R1 irq", irq, 0);

    // R3: corrected strobe ignored while correction disabled
    fix_off = 1;
    for (int k = 0; k < 3; k++) pulse(3);
    rd(3, v); check("R3", v, 0);
    fix_off = 0;

    // R2 R5 R7: full sweep with wrap, non-clearing reads
    for (int i = 0; i < 5; i++)
      for (int k = 1; k <= M + 3; k++) begin
        pulse(i);
        exp_c[i] = (exp_c[i] + 1) % M;
        if (exp_c[i] == 0) exp_s |= (1 << i);
        rd(i, v); check("R2/R5 count", v, exp_c[i]);
        rd(i, v); check("R5 unchanged", v, exp_c[i]);
      end
    rd(5, v); check("R7 status", v, exp_s);

    // R9: mask and irq
    check("R9 irq masked", irq, 0);
    for (int j = 0; j < 5; j++) begin
      wr(6, 1 << j);
      rd(6, v); check("R9 mask readback", v, 1 << j);
      check("R9 irq", irq, 1);
    end
    // R8: write-one-to-clear
    wr(5, 1);
    exp_s &= ~1;
    rd(5, v); check("R8 w1c", v, exp_s);
    wr(6, 1);
    check("R9 irq off", irq, 0);
    wr(6, 2);
    check("R9 irq on", irq, 1);

    // R4: clearing read
    keep_on_read = 0;
    rd(0, v); check("R4 read value", v, exp_c[0]);
    exp_c[0] = 0;
    rd(0, v); check("R4 cleared", v, 0);

    // R6: event coincides with clearing read
    @(negedge clk); rd_en = 1; addr = 3'd1; evs[1] = 1;
    @(negedge clk); rd_en = 0; evs = '0; v = rdata;
    check("R6 pre-read value", v, exp_c[1]);
    exp_c[1] = 1;
    keep_on_read = 1;
    rd(1, v); check("R6 counter is one", v, 1);

    // R10: unmapped address
    keep_on_read = 0;
    rd(7, v); check("R10 zero", v, 0);
    keep_on_read = 1;
    for (int i = 0; i < 5; i++) begin rd(i, v); check("R10 no side effect", v, exp_c[i]); end

    // R8: wrap wins over same-cycle clear
    wr(5, 31);
    rd(5, v); check("R8 all cleared", v, 0);
    for (int k = exp_c[2]; k < M - 1; k++) pulse(2);
    @(negedge clk); wr_en = 1; addr = 3'd5; wdata = 5'd4; evs[2] = 1;
    @(negedge clk); wr_en = 0; evs = '0;
    rd(5, v); check("R8 set beats clear", v, 4);
    rd(2, v); check("R7 wrapped", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule